// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the master side of a three-wire serial link to a 12-bit successive-approximation converter. The converter runs its conversion from the serial clock it receives. The controller makes that clock from the system clock with a programmable half-period divider. It pulls chip select low for one fixed frame of sixteen serial clocks, samples the returned bit stream on falling serial-clock edges, checks the leading bits and hands the 12-bit result to the core as a one-cycle strobe.

A conversion starts either on a start request or, while auto-run is enabled, one frame after another. After every frame, chip select stays high for a minimum number of system cycles. The controller also drives an active-low power-down line to the converter from a register input. While that line is asserted, no frame is started.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, and after any later reset, `cs_n_o` is 1, `sclk_o` is 0, `res_valid_o` is 0, `frame_err_o` is 0 and `shdn_n_o` is 1.
- R2: Each frame has exactly 16 rising edges of `sclk_o` while `cs_n_o` is 0. `sclk_o` is 0 whenever `cs_n_o` is 1.
- R3: The half period of `sclk_o` is the value of `div_half_i` in system cycles, clamped to the range 10 to 125. The value is taken when the frame starts.
- R4: The first rising edge of `sclk_o` comes exactly one half period after `cs_n_o` falls.
- R5: `sdata_i` is sampled at each falling edge of `sclk_o`. Falling edges 4 to 15 (counted from 1) carry the result, MSB first. In the system cycle where `cs_n_o` rises, `res_valid_o` is 1 for exactly one cycle with the result on `res_data_o`. Values on `sdata_i` while `cs_n_o` is 1 have no effect.
- R6: If a 1 is sampled on any of falling edges 1 to 3, `frame_err_o` rises when that frame ends. It then stays at 1 until reset.
- R7: Between frames, `cs_n_o` stays high for at least 13 system cycles.
- R8: `shdn_n_o` follows the inverse of `pwr_dn_i` one cycle later. While `pwr_dn_i` is 1 or `shdn_n_o` is 0, no frame starts, whether requested by `start_i` or by `auto_en_i`.
- R9: A `start_i` pulse while a frame or the gap after it is in progress is ignored and starts no extra frame.
- R10: While `auto_en_i` is 1, a new frame starts as soon as the gap after the previous one has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half_i | input | 8 | Requested serial-clock half period in system cycles |
| start_i | input | 1 | Request one conversion frame |
| auto_en_i | input | 1 | Run frames back to back |
| pwr_dn_i | input | 1 | Power-down request for the converter |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| shdn_n_o | output | 1 | Active-low power-down to the converter |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Conversion result |
| frame_err_o | output | 1 | Sticky leading-bit error flag |

## Verification
The hardest case to reach is a start request that arrives inside a running frame or during the gap after it. The bench sends a second start pulse a hundred cycles into a frame. It then counts chip-select falls and checks that only one result arrives. The same counting covers auto-run: the bench releases auto-run in the cycle the third result appears, which is still inside the gap, and checks that no fourth frame follows. Serial-clock timing is measured from the pins for each frame, with divider settings below, inside and above the allowed range.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Sequencer states: waiting, frame on the wire, chip-select recovery.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_e;

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 10,
  parameter int DIV_MAX = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             sclk_o,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] HALF_LO = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HALF_HI = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] half_q, half_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  // Latch the clamped half period at frame start only.
  always_comb begin
    half_d = half_q;
    if (load_i) begin
      if (div_i < HALF_LO)      half_d = HALF_LO;
      else if (div_i > HALF_HI) half_d = HALF_HI;
      else                      half_d = div_i;
    end
  end

  assign tick = run_i && (cnt_q == half_q - DIV_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_LO;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign tick_o = tick;

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_rd_pkg::*;
#(
  parameter int FRAME_CLKS = 16,
  parameter int GAP_CYC    = 13,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             tick_i,
  input  logic             sclk_i,
  output logic             start_o,
  output logic             run_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             done_o,
  output logic             cs_n_o
);

  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_CLKS - 1);
  localparam logic [GW-1:0]    GAP_LAST  = GW'(GAP_CYC - 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] fc_q, fc_d;
  logic [GW-1:0]    gc_q, gc_d;
  logic             cs_n_q, cs_n_d;

  always_comb begin
    st_d    = st_q;
    fc_d    = fc_q;
    gc_d    = gc_q;
    start_o = 1'b0;
    fall_o  = 1'b0;
    done_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (go_i) begin
          st_d    = ST_ACT;
          fc_d    = '0;
          start_o = 1'b1;
        end
      end
      ST_ACT: begin
        if (tick_i && sclk_i) begin
          fall_o = 1'b1;
          if (fc_q == LAST_FALL) begin
            done_o = 1'b1;
            st_d   = ST_GAP;
            gc_d   = '0;
          end else begin
            fc_d = fc_q + CNT_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (gc_q == GAP_LAST) st_d = ST_IDLE;
        else                  gc_d = gc_q + GW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
    cs_n_d = (st_d != ST_ACT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_GAP;
      fc_q   <= '0;
      gc_q   <= '0;
      cs_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      fc_q   <= fc_d;
      gc_q   <= gc_d;
      cs_n_q <= cs_n_d;
    end
  end

  assign run_o  = (st_q == ST_ACT);
  assign idx_o  = fc_q;
  assign cs_n_o = cs_n_q;

endmodule

// File: rtl/adc_bit_cap.sv
module adc_bit_cap #(
  parameter int DATA_W    = 12,
  parameter int LEAD_BITS = 3,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic              sd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bad_o
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              bad_q, bad_d;
  logic              in_lead, in_data;

  generate
    if (LEAD_BITS > 0) begin : g_lead
      assign in_lead = (idx_i < CNT_W'(LEAD_BITS));
    end else begin : g_nolead
      assign in_lead = 1'b0;
    end
  endgenerate

  assign in_data = !in_lead && (idx_i < CNT_W'(LEAD_BITS + DATA_W));

  always_comb begin
    data_d = data_q;
    bad_d  = bad_q;
    if (clr_i) begin
      data_d = '0;
      bad_d  = 1'b0;
    end else if (fall_i) begin
      if (in_lead)      bad_d  = bad_q | sd_i;
      else if (in_data) data_d = {data_q[DATA_W-2:0], sd_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      bad_q  <= bad_d;
    end
  end

  assign data_o = data_q;
  assign bad_o  = bad_q;

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DATA_W      = 12,
  parameter int LEAD_BITS   = 3,
  parameter int TAIL_BITS   = 1,
  parameter int DIV_W       = 8,
  parameter int DIV_MIN     = 10,
  parameter int DIV_MAX     = 125,
  parameter int GAP_CYC     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_half_i,
  input  logic              start_i,
  input  logic              auto_en_i,
  input  logic              pwr_dn_i,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              shdn_n_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              frame_err_o
);

  localparam int FRAME_CLKS = LEAD_BITS + DATA_W + TAIL_BITS;
  localparam int CNT_W      = $clog2(FRAME_CLKS + 1);

  logic                   shdn_n_q, shdn_n_d;
  logic                   valid_q, valid_d;
  logic [DATA_W-1:0]      data_q, data_d;
  logic                   err_q, err_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sd_s;
  logic                   go, start, run, tick, fall, done;
  logic                   sclk_int;
  logic [CNT_W-1:0]       idx;
  logic [DATA_W-1:0]      cap_data;
  logic                   cap_bad;

  // Input synchronizer for the returned serial data.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sdata_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end
  assign sd_s = sync_q[SYNC_STAGES-1];

  assign go = (start_i | auto_en_i) & shdn_n_q & ~pwr_dn_i;

  adc_frame_seq #(
    .FRAME_CLKS (FRAME_CLKS),
    .GAP_CYC    (GAP_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go),
    .tick_i  (tick),
    .sclk_i  (sclk_int),
    .start_o (start),
    .run_o   (run),
    .fall_o  (fall),
    .idx_o   (idx),
    .done_o  (done),
    .cs_n_o  (cs_n_o)
  );

  adc_sclk_gen #(
    .DIV_W   (DIV_W),
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX)
  ) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .div_i  (div_half_i),
    .run_i  (run),
    .sclk_o (sclk_int),
    .tick_o (tick)
  );

  adc_bit_cap #(
    .DATA_W    (DATA_W),
    .LEAD_BITS (LEAD_BITS),
    .CNT_W     (CNT_W)
  ) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start),
    .fall_i (fall),
    .idx_i  (idx),
    .sd_i   (sd_s),
    .data_o (cap_data),
    .bad_o  (cap_bad)
  );

  always_comb begin
    shdn_n_d = ~pwr_dn_i;
    valid_d  = done;
    data_d   = done ? cap_data : data_q;
    err_d    = err_q | (done & cap_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shdn_n_q <= 1'b1;
      valid_q  <= 1'b0;
      data_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      shdn_n_q <= shdn_n_d;
      valid_q  <= valid_d;
      data_q   <= data_d;
      err_q    <= err_d;
    end
  end

  assign sclk_o      = sclk_int;
  assign shdn_n_o    = shdn_n_q;
  assign res_valid_o = valid_q;
  assign res_data_o  = data_q;
  assign frame_err_o = err_q;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int FRAME_CLKS = 16,
  parameter int DIV_MAX    = 125
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic sclk_o,
  input logic shdn_n_o,
  input logic res_valid_o,
  input logic frame_err_o
);

  localparam int HW = $clog2(DIV_MAX + 3);
  localparam int RW = $clog2(FRAME_CLKS + 3);

  logic          sclk_d;
  logic [HW-1:0] hold_cnt;
  logic [RW-1:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      hold_cnt <= '0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_n_o || (sclk_o != sclk_d)) hold_cnt <= '0;
      else if (hold_cnt < HW'(DIV_MAX + 2)) hold_cnt <= hold_cnt + HW'(1);
      if (cs_n_o) rise_cnt <= '0;
      else if (sclk_o && !sclk_d && rise_cnt < RW'(FRAME_CLKS + 2)) rise_cnt <= rise_cnt + RW'(1);
    end
  end

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R2
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= RW'(FRAME_CLKS));

  // R3
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= HW'(DIV_MAX + 1));

  // R4
  setup_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |=> !sclk_o);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R5
  valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $rose(cs_n_o));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> frame_err_o);

  // R8
  start_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> shdn_n_o);

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .FRAME_CLKS (LEAD_BITS + DATA_W + TAIL_BITS),
  .DIV_MAX    (DIV_MAX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .shdn_n_o    (shdn_n_o),
  .res_valid_o (res_valid_o),
  .frame_err_o (frame_err_o)
);

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;

  localparam int GAP_CYC = 13;
  localparam int NCLK    = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_half_i = 8'd10;
  logic        start_i = 1'b0;
  logic        auto_en_i = 1'b0;
  logic        pwr_dn_i = 1'b0;
  logic        sd = 1'b1;
  logic        cs_n_o, sclk_o, shdn_n_o, res_valid_o, frame_err_o;
  logic [11:0] res_data_o;

  always #4 clk = ~clk;

  adc_rd_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_half_i  (div_half_i),
    .start_i     (start_i),
    .auto_en_i   (auto_en_i),
    .pwr_dn_i    (pwr_dn_i),
    .sdata_i     (sd),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .shdn_n_o    (shdn_n_o),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_data_o),
    .frame_err_o (frame_err_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  int frames = 0, results = 0, rises = 0;
  int exp_half = 10;
  int cs_fall_cyc = 0, cs_rise_cyc = 0, last_rise = 0;
  bit seen_rise = 1'b0;
  logic pcs = 1'b1, psclk = 1'b0;
  logic [11:0] exp_q[$];
  logic [15:0] slv_q[$];
  logic [15:0] cur = 16'h0;
  int k = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Behavioural converter: shifts out its frame on rising serial-clock edges.
  always @(negedge cs_n_o or posedge cs_n_o or posedge sclk_o) begin
    if (cs_n_o) sd = 1'b1;
    else if (!sclk_o) begin
      cur = (slv_q.size() != 0) ? slv_q.pop_front() : 16'h0;
      k   = 0;
      sd  = 1'b1;
    end else begin
      if (k < NCLK) sd = cur[15-k];
      k++;
    end
  end

  // Monitor and scoreboard, sampling away from the active edge.
  always @(negedge clk) begin
    logic [11:0] e;
    cyc++;
    if (res_valid_o) begin
      results++;
      if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected result", res_data_o, 0);
      else begin
        e = exp_q.pop_front();
        chk(res_data_o == e, "R5", "result data", res_data_o, e);
      end
      chk(cs_n_o == 1'b1, "R5", "cs high with strobe", cs_n_o, 1);
    end
    if (pcs && !cs_n_o) begin
      frames++;
      if (seen_rise) chk(cyc - cs_rise_cyc >= GAP_CYC, "R7", "cs high gap", cyc - cs_rise_cyc, GAP_CYC);
      cs_fall_cyc = cyc;
      rises = 0;
    end
    if (!pcs && cs_n_o) begin
      chk(rises == NCLK, "R2", "rising edges per frame", rises, NCLK);
      cs_rise_cyc = cyc;
      seen_rise = 1'b1;
    end
    if (!cs_n_o && sclk_o && !psclk) begin
      rises++;
      if (rises == 1) chk(cyc - cs_fall_cyc == exp_half, "R4", "cs fall to first rise", cyc - cs_fall_cyc, exp_half);
      else chk(cyc - last_rise == 2*exp_half, "R3", "sclk period", cyc - last_rise, 2*exp_half);
      last_rise = cyc;
    end
    if (cs_n_o && sclk_o) chk(1'b0, "R2", "sclk high while idle", 1, 0);
    pcs = cs_n_o;
    psclk = sclk_o;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // Driver: queues the converter frame and the expected result, then starts it.
  task automatic run_frame(input logic [2:0] lead, input logic [11:0] d);
    int r0;
    r0 = results;
    slv_q.push_back({lead, d, 1'b0});
    exp_q.push_back(d);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (results == r0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int f0;
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 1'b1, "R1", "cs_n in reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R1", "sclk in reset", sclk_o, 0);
    chk(res_valid_o == 1'b0, "R1", "valid in reset", res_valid_o, 0);
    chk(frame_err_o == 1'b0, "R1", "err in reset", frame_err_o, 0);
    chk(shdn_n_o == 1'b1, "R1", "shdn_n in reset", shdn_n_o, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R5 R3 data patterns at the fastest setting
    run_frame(3'b000, 12'hABC);
    run_frame(3'b000, 12'h000);
    run_frame(3'b000, 12'hFFF);
    run_frame(3'b000, 12'h801);

    // R3 clamp below minimum, above maximum, and in range
    div_half_i = 8'd3;   exp_half = 10;  run_frame(3'b000, 12'h555);
    div_half_i = 8'd200; exp_half = 125; run_frame(3'b000, 12'h2AA);
    div_half_i = 8'd37;  exp_half = 37;  run_frame(3'b000, 12'h123);
    div_half_i = 8'd10;  exp_half = 10;

    // R9 second start inside a running frame
    f0 = frames;
    r0 = results;
    slv_q.push_back({3'b000, 12'h9E7, 1'b0});
    exp_q.push_back(12'h9E7);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (100) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (results == r0) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(frames == f0 + 1, "R9", "frames after busy start", frames - f0, 1);

    // R8 power-down blocks start and auto-run
    pwr_dn_i = 1'b1;
    @(negedge clk);
    chk(shdn_n_o == 1'b0, "R8", "shdn_n asserted", shdn_n_o, 0);
    f0 = frames;
    start_i = 1'b1; auto_en_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (200) @(negedge clk);
    auto_en_i = 1'b0;
    chk(frames == f0, "R8", "frames while powered down", frames - f0, 0);
    pwr_dn_i = 1'b0;
    @(negedge clk);
    chk(shdn_n_o == 1'b1, "R8", "shdn_n released", shdn_n_o, 1);
    repeat (5) @(negedge clk);

    // R10 auto-run back to back
    f0 = frames;
    r0 = results;
    slv_q.push_back({3'b000, 12'h111, 1'b0}); exp_q.push_back(12'h111);
    slv_q.push_back({3'b000, 12'hE0F, 1'b0}); exp_q.push_back(12'hE0F);
    slv_q.push_back({3'b000, 12'h7C4, 1'b0}); exp_q.push_back(12'h7C4);
    auto_en_i = 1'b1;
    while (results < r0 + 3) @(negedge clk);
    auto_en_i = 1'b0;
    repeat (100) @(negedge clk);
    chk(frames == f0 + 3, "R10", "auto-run frame count", frames - f0, 3);

    // R6 leading-bit error, then stickiness
    chk(frame_err_o == 1'b0, "R6", "err clear before bad frame", frame_err_o, 0);
    run_frame(3'b001, 12'h3C3);
    chk(frame_err_o == 1'b1, "R6", "err after bad lead bit", frame_err_o, 1);
    run_frame(3'b000, 12'h0F0);
    chk(frame_err_o == 1'b1, "R6", "err sticky", frame_err_o, 1);

    // R1 second reset clears the flag
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(frame_err_o == 1'b0, "R1", "err after reset", frame_err_o, 0);
    chk(cs_n_o == 1'b1, "R1", "cs_n after reset", cs_n_o, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(exp_q.size() == 0, "R5", "results outstanding", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule